// File: doc/BRIEF.md
# GPIO port register bank

A bus-addressed register file that controls a grid of general-purpose pins. The pins are grouped into banks, every bank into four ports, and every port into eight pins. For each port the block keeps a direction-control pair (pin mode and output enable), an output value, and three interrupt-related bytes: pending status, enable and trigger type. These are stored here for a separate edge and level detection block, which reads them from the block's outputs. The pad inputs pass through a two-flop synchronizer and can be read back through a read-only input register.

Software reaches every port through a plain word address. It can also use a masked alias of each writable register. The alias changes only the pins it selects, so no read-modify-write sequence is needed and no lock is needed between agents that share a port. Reads are combinational from the address. Writes take effect at the rising clock edge on which `bus_we` is high.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every stored register reads 0x00, and `pad_oe`, `pad_out`, `irq_en` and `irq_type` are all zero, so every pin starts as an input.
- R2: A plain write to `bank*0x80 + port*4 + off` stores `wdata[7:0]` into the addressed port's register. The offsets are 0x00 mode, 0x10 output enable, 0x20 output value, 0x40 interrupt status, 0x50 interrupt enable and 0x60 trigger type. The same address then reads the value back in `rdata[7:0]`, with `rdata[31:8]` zero.
- R3: A write to plain address + 0x800 is masked. For pin i, data bit 8+i set means the pin takes data bit i. Pins whose bit 8+i is clear keep their value, so a masked write with `wdata[15:8]` zero changes nothing.
- R4: Pin n = bank*32 + port*8 + bit. `pad_oe[n]` is 1 only when both the mode bit and the output-enable bit of that pin are 1. `pad_out[n]` equals the stored output-value bit.
- R5: Offset 0x30 is read-only and returns the pad inputs after two clock edges of synchronization. A change on `pad_in` is still invisible after one rising edge and visible after the second. Writes to 0x30 are ignored.
- R6: A plain write to offset 0x70 clears the status bits whose data bit is 1 and leaves the others set. A read of 0x70 returns zero.
- R7: Reads return zero from unmapped addresses: a bank number of 7 or more, address bit 10 set, address bits [1:0] non-zero, the alias of offsets 0x30 and 0x70, and any read of the alias range (+0x800). Writes to these addresses change no register.
- R8: `irq_en[n]` and `irq_type[n]` equal the stored interrupt-enable and trigger-type bits of pin n.
- R9: Register state changes only on a cycle with `bus_we` high, and a write changes only the addressed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data; bits [15:0] used |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 224 | Raw pad input levels, asynchronous |
| pad_out | output | 224 | Per-pin output value |
| pad_oe | output | 224 | Per-pin output drive enable |
| irq_en | output | 224 | Per-pin interrupt enable for the detector |
| irq_type | output | 224 | Per-pin trigger type for the detector |

## Verification
The hardest case to reach from the ports is the masked update that mixes selected and unselected pins while the register already holds a pattern that differs from the new data. If the mask were ignored, or its two bytes swapped, a freshly reset register would hide the fault. The bench therefore first loads a known byte with a plain write. It then issues masked writes whose select and value bytes overlap only partly, and it also sends a write with an empty select byte. The synchronizer latency is checked by moving `pad_in` and reading the input register after exactly one rising edge and again after the second.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int LANE_W = 8;

   typedef enum logic [2:0] {
      RG_MODE = 3'd0,
      RG_OE   = 3'd1,
      RG_OUT  = 3'd2,
      RG_IN   = 3'd3,
      RG_STA  = 3'd4,
      RG_IEN  = 3'd5,
      RG_TYP  = 3'd6,
      RG_CLR  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
   import gpio_rb_pkg::*;
#(
   parameter int NUM_BANKS      = 7,
   parameter int PORTS_PER_BANK = 4,
   localparam int NPORTS        = NUM_BANKS * PORTS_PER_BANK,
   localparam int IDX_W         = $clog2(NPORTS > 1 ? NPORTS : 2)
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          rsel,
   output logic              masked,
   output logic [IDX_W-1:0]  idx,
   output logic              wr_ok,
   output logic              rd_ok
);
   logic loc_ok, aliasable;

   always_comb begin
      rsel      = reg_sel_e'(addr[6:4]);
      masked    = addr[11];
      loc_ok    = (addr[1:0] == 2'b00) && !addr[10]
                  && (32'(addr[9:7]) < NUM_BANKS)
                  && (32'(addr[3:2]) < PORTS_PER_BANK);
      aliasable = (rsel != RG_IN) && (rsel != RG_CLR);
      wr_ok     = loc_ok && (masked ? aliasable : (rsel != RG_IN));
      rd_ok     = loc_ok && !masked && (rsel != RG_CLR);
      idx       = IDX_W'(32'(addr[9:7]) * PORTS_PER_BANK + 32'(addr[3:2]));
   end
endmodule

// File: rtl/gpio_rb_port.sv
module gpio_rb_port
   import gpio_rb_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             masked,
   input  reg_sel_e         rsel,
   input  logic [15:0]      wdata,
   output logic [PINS-1:0]  mode_o,
   output logic [PINS-1:0]  oe_o,
   output logic [PINS-1:0]  out_o,
   output logic [PINS-1:0]  sta_o,
   output logic [PINS-1:0]  ien_o,
   output logic [PINS-1:0]  typ_o
);
   logic [PINS-1:0] sel_bits, val_bits;

   assign val_bits = wdata[PINS-1:0];
   assign sel_bits = masked ? wdata[LANE_W +: PINS] : {PINS{1'b1}};

   function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old,
                                             input logic [PINS-1:0] sel,
                                             input logic [PINS-1:0] val);
      return (old & ~sel) | (val & sel);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= '0;
         oe_o   <= '0;
         out_o  <= '0;
         sta_o  <= '0;
         ien_o  <= '0;
         typ_o  <= '0;
      end else if (wr) begin
         case (rsel)
            RG_MODE: mode_o <= merge(mode_o, sel_bits, val_bits);
            RG_OE:   oe_o   <= merge(oe_o,   sel_bits, val_bits);
            RG_OUT:  out_o  <= merge(out_o,  sel_bits, val_bits);
            RG_STA:  sta_o  <= merge(sta_o,  sel_bits, val_bits);
            RG_IEN:  ien_o  <= merge(ien_o,  sel_bits, val_bits);
            RG_TYP:  typ_o  <= merge(typ_o,  sel_bits, val_bits);
            RG_CLR:  sta_o  <= sta_o & ~val_bits;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_rb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_rb_pkg::*;
#(
   parameter int NUM_BANKS      = 7,
   parameter int PORTS_PER_BANK = 4,
   parameter int PINS_PER_PORT  = 8,
   parameter int SYNC_STAGES    = 2,
   localparam int NPORTS        = NUM_BANKS * PORTS_PER_BANK,
   localparam int NPINS         = NPORTS * PINS_PER_PORT,
   localparam int IDX_W         = $clog2(NPORTS > 1 ? NPORTS : 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  irq_en,
   output logic [NPINS-1:0]  irq_type
);
   if (NUM_BANKS < 1 || NUM_BANKS > 8) begin : g_bad_banks
      $error("gpio_regbank: NUM_BANKS must be 1..8");
   end
   if (PORTS_PER_BANK < 1 || PORTS_PER_BANK > 4) begin : g_bad_ports
      $error("gpio_regbank: PORTS_PER_BANK must be 1..4");
   end
   if (PINS_PER_PORT < 1 || PINS_PER_PORT > LANE_W) begin : g_bad_pins
      $error("gpio_regbank: PINS_PER_PORT must be 1..8");
   end

   reg_sel_e         rsel;
   logic             masked, wr_ok, rd_ok;
   logic [IDX_W-1:0] idx;
   logic [NPINS-1:0] mode_v, oe_v, out_v, sta_v, ien_v, typ_v, in_sync;
   logic [DATA_W-1:0] rd_word;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:16];

   gpio_rb_decode #(
      .NUM_BANKS      (NUM_BANKS),
      .PORTS_PER_BANK (PORTS_PER_BANK)
   ) u_dec (
      .addr   (bus_addr),
      .rsel   (rsel),
      .masked (masked),
      .idx    (idx),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      assign hit = bus_we && wr_ok && (idx == IDX_W'(p));
      gpio_rb_port #(.PINS(PINS_PER_PORT)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (hit),
         .masked (masked),
         .rsel   (rsel),
         .wdata  (bus_wdata[15:0]),
         .mode_o (mode_v[p*PINS_PER_PORT +: PINS_PER_PORT]),
         .oe_o   (oe_v  [p*PINS_PER_PORT +: PINS_PER_PORT]),
         .out_o  (out_v [p*PINS_PER_PORT +: PINS_PER_PORT]),
         .sta_o  (sta_v [p*PINS_PER_PORT +: PINS_PER_PORT]),
         .ien_o  (ien_v [p*PINS_PER_PORT +: PINS_PER_PORT]),
         .typ_o  (typ_v [p*PINS_PER_PORT +: PINS_PER_PORT])
      );
   end

   gpio_rb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (rd_ok && idx == IDX_W'(p)) begin
            case (rsel)
               RG_MODE: rd_word[PINS_PER_PORT-1:0] = mode_v [p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_OE:   rd_word[PINS_PER_PORT-1:0] = oe_v   [p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_OUT:  rd_word[PINS_PER_PORT-1:0] = out_v  [p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_IN:   rd_word[PINS_PER_PORT-1:0] = in_sync[p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_STA:  rd_word[PINS_PER_PORT-1:0] = sta_v  [p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_IEN:  rd_word[PINS_PER_PORT-1:0] = ien_v  [p*PINS_PER_PORT +: PINS_PER_PORT];
               RG_TYP:  rd_word[PINS_PER_PORT-1:0] = typ_v  [p*PINS_PER_PORT +: PINS_PER_PORT];
               default: ;
            endcase
         end
      end
   end

   assign bus_rdata = rd_word;
   assign pad_oe    = mode_v & oe_v;
   assign pad_out   = out_v;
   assign irq_en    = ien_v;
   assign irq_type  = typ_v;
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int NPINS = 224
) (
   input logic              clk,
   input logic              rst_n,
   input logic [11:0]       bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_we,
   input logic [31:0]       bus_rdata,
   input logic [NPINS-1:0]  pad_in,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  irq_en,
   input logic [NPINS-1:0]  irq_type
);
   logic [1:0] since_rst;
   logic       unused_wdata;

   assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[7:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(pad_oe) && $stable(pad_out)
                   && $stable(irq_en) && $stable(irq_type)));

   // R3
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11] && bus_wdata[15:8] == 8'h00)
      |=> ($stable(pad_oe) && $stable(pad_out)
           && $stable(irq_en) && $stable(irq_type)));

   // R6
   clear_only_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11:10] == 2'b00 && bus_addr[6:4] == 3'd7)
      |=> ($stable(pad_oe) && $stable(pad_out)
           && $stable(irq_en) && $stable(irq_type)));

   // R7
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[11] || bus_addr[10]) |-> (bus_rdata == 32'h0));

   // R5
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && bus_addr == 12'h030)
      |-> (bus_rdata[0] == $past(pad_in[0], 2)));
endmodule

bind gpio_regbank gpio_regbank_chk #(
   .NPINS(NUM_BANKS * PORTS_PER_BANK * PINS_PER_PORT)
) u_chk (.*);

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
   localparam int NPINS = 224;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [11:0]      bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic             bus_we = 1'b0;
   logic [31:0]      bus_rdata;
   logic [NPINS-1:0] pad_in = '0;
   logic [NPINS-1:0] pad_out, pad_oe, irq_en, irq_type;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   gpio_regbank uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_en(irq_en), .irq_type(irq_type)
   );

   function automatic logic [11:0] ra(input int bank, input int port,
                                      input int off, input bit alias_sel);
      return 12'((alias_sel ? 'h800 : 0) + bank * 'h80 + port * 4 + off);
   endfunction

   function automatic int pbase(input int bank, input int port);
      return bank * 32 + port * 8;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(ra(0,0,'h00,0), d); check("R1 mode", d, 0);
      rd(ra(6,3,'h20,0), d); check("R1 out",  d, 0);
      rd(ra(3,1,'h50,0), d); check("R1 ien",  d, 0);
      check("R1 pad_oe",  32'(|pad_oe), 0);
      check("R1 pad_out", 32'(|pad_out), 0);
      check("R1 irq",     32'(|{irq_en, irq_type}), 0);
   endtask

   task automatic t_plain;
      logic [31:0] d;
      wr(ra(2,1,'h00,0), 32'hFFFF_12A5);
      rd(ra(2,1,'h00,0), d); check("R2 mode readback", d, 32'h0000_00A5);
      rd(ra(2,2,'h00,0), d); check("R9 neighbour port", d, 0);
      rd(ra(1,1,'h00,0), d); check("R9 neighbour bank", d, 0);
      wr(ra(2,1,'h40,0), 32'h0000_003C);
      rd(ra(2,1,'h40,0), d); check("R2 status readback", d, 32'h3C);
   endtask

   task automatic t_masked;
      logic [31:0] d;
      wr(ra(4,0,'h20,0), 32'h0F);
      wr(ra(4,0,'h20,1), 32'h0000_3C28);
      rd(ra(4,0,'h20,0), d); check("R3 masked merge", d, 32'h2B);
      check("R4 pad_out slice", 32'(pad_out[pbase(4,0) +: 8]), 32'h2B);
      wr(ra(4,0,'h20,1), 32'h0000_00FF);
      rd(ra(4,0,'h20,0), d); check("R3 empty select", d, 32'h2B);
      wr(ra(4,0,'h20,1), 32'h0000_FF00);
      rd(ra(4,0,'h20,0), d); check("R3 full select zero", d, 0);
   endtask

   task automatic t_drive;
      wr(ra(3,2,'h00,0), 32'hFF);
      wr(ra(3,2,'h10,1), 32'h0101);
      check("R4 oe one pin", 32'(pad_oe[pbase(3,2) +: 8]), 32'h01);
      wr(ra(3,2,'h10,0), 32'hFF);
      wr(ra(3,2,'h00,1), 32'hF000);
      check("R4 oe needs mode", 32'(pad_oe[pbase(3,2) +: 8]), 32'h0F);
      wr(ra(3,2,'h20,0), 32'h55);
      check("R4 out slice", 32'(pad_out[pbase(3,2) +: 8]), 32'h55);
   endtask

   task automatic t_input;
      logic [31:0] d;
      @(negedge clk);
      pad_in[pbase(1,3) +: 8] = 8'hC3;
      @(posedge clk); @(negedge clk);
      rd(ra(1,3,'h30,0), d); check("R5 one edge", d, 0);
      @(posedge clk); @(negedge clk);
      rd(ra(1,3,'h30,0), d); check("R5 two edges", d, 32'hC3);
      wr(ra(1,3,'h30,0), 32'h00);
      rd(ra(1,3,'h30,0), d); check("R5 write ignored", d, 32'hC3);
   endtask

   task automatic t_clear;
      logic [31:0] d;
      wr(ra(5,3,'h40,0), 32'hFF);
      wr(ra(5,3,'h70,0), 32'h0F);
      rd(ra(5,3,'h40,0), d); check("R6 partial clear", d, 32'hF0);
      rd(ra(5,3,'h70,0), d); check("R6 clear reads zero", d, 0);
      wr(ra(5,3,'h40,1), 32'h0303);
      rd(ra(5,3,'h40,0), d); check("R3 status alias", d, 32'hF3);
   endtask

   task automatic t_irq_cfg;
      wr(ra(6,1,'h50,1), 32'h8181);
      wr(ra(6,1,'h60,0), 32'h5A);
      check("R8 irq_en",   32'(irq_en  [pbase(6,1) +: 8]), 32'h81);
      check("R8 irq_type", 32'(irq_type[pbase(6,1) +: 8]), 32'h5A);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      logic [NPINS-1:0] s_oe, s_out, s_en, s_ty;
      s_oe = pad_oe; s_out = pad_out; s_en = irq_en; s_ty = irq_type;
      wr(12'h380, 32'hFF);
      wr(12'h401, 32'hFF);
      wr(ra(0,0,'h30,1), 32'hFFFF);
      wr(ra(0,0,'h70,1), 32'hFFFF);
      wr(12'h402, 32'hFF);
      wr(12'h020 | 12'h400, 32'hFF);
      check("R7 writes no effect", 32'({pad_oe, pad_out, irq_en, irq_type}
            == {s_oe, s_out, s_en, s_ty}), 1);
      rd(12'h001, d); check("R7 misaligned read", d, 0);
      rd(12'h380, d); check("R7 bank 7 read", d, 0);
      rd(ra(2,1,'h00,1), d); check("R7 alias read", d, 0);
      rd(ra(1,3,'h30,0) | 12'h400, d); check("R7 bit10 read", d, 0);
      rd(ra(0,0,'h00,0), d); check("R7 misaligned write ignored", d, 0);
   endtask

   initial begin
      #500000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_plain;
      t_masked;
      t_drive;
      t_input;
      t_clear;
      t_irq_cfg;
      t_unmapped;
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule